// File: doc/BRIEF.md
# Compact Byte ALU with Carry and Zero Flags

This block is the arithmetic and logic core of a small soft processor that takes two clocks per instruction. The first operand always comes from a register, and that register also receives the result. A select line takes the second operand from either a second register or an 8-bit immediate carried in the instruction. A two-bit group code chooses a bitwise logic operation, an add/subtract, a single-bit shift or rotate, or a value read from an external input port. The result and the flags are captured in registers in the same cycle that the execute strobe is high, which leaves a full clock period for the operand path.

The logic operations come from one per-bit four-way selection. All four add and subtract forms share one adder, and a single carry-in rule tells them apart. Every shift and rotate form uses the same left/right bit selection plus a selector for the bit that fills the vacated end. One final four-way select merges the three groups and the input port.

Top module: `byte_alu`

## Requirements
- R1: With `useImm`=1 the second operand is `imm`. With `useImm`=0 it is `regB`.
- R2: For group 0 (logic), `subOp` 0 passes the second operand through, 1 gives AND, 2 gives OR and 3 gives XOR of `regA` with the second operand.
- R3: For group 1 (arithmetic), `subOp` 0 gives A+B and `subOp` 1 gives A+B+CARRY. CARRY then holds the carry out of bit 7.
- R4: For group 1, `subOp` 2 gives A−B and `subOp` 3 gives A−B−CARRY. CARRY then holds the borrow (1 when the true difference is negative).
- R5: For group 2 (shift) with `shiftRight`=0, the result is `regA` moved one place toward the MSB and CARRY takes the old bit 7. The bit entering bit 0 is chosen by `injSel`: 0 gives `injConst`, 1 gives CARRY, 2 gives old bit 7 (rotate), 3 gives old bit 0.
- R6: For group 2 with `shiftRight`=1, the result is `regA` moved one place toward the LSB and CARRY takes the old bit 0. The bit entering bit 7 is chosen by `injSel`: 0 gives `injConst`, 1 gives CARRY, 2 gives old bit 0 (rotate), 3 gives old bit 7 (arithmetic shift).
- R7: For group 3 (port) the result is `portIn`, and CARRY and ZERO keep their values.
- R8: Every logic-group operation clears CARRY.
- R9: For groups 0 to 2, ZERO is 1 exactly when the new 8-bit result is 0.
- R10: While `valid` is 0, `result`, `carry` and `zero` do not change.
- R11: The result and flags appear one clock edge after the edge that samples `valid`=1, and `resultValid` is high for that cycle. Reset clears `result`, `carry`, `zero` and `resultValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Execute strobe for one operation |
| opGroup | input | 2 | 0 logic, 1 arithmetic, 2 shift/rotate, 3 input port |
| subOp | input | 2 | Operation within the logic or arithmetic group |
| shiftRight | input | 1 | Shift direction: 1 toward LSB, 0 toward MSB |
| injSel | input | 2 | Choice of the bit that fills the vacated end |
| injConst | input | 1 | Constant fill bit used when `injSel`=0 |
| useImm | input | 1 | Second operand select: 1 immediate, 0 register |
| regA | input | 8 | First operand, from the destination register |
| regB | input | 8 | Second register operand |
| imm | input | 8 | Immediate from the instruction |
| portIn | input | 8 | External input port value |
| result | output | 8 | Registered result |
| carry | output | 1 | CARRY flag |
| zero | output | 1 | ZERO flag |
| resultValid | output | 1 | High for the cycle after an executed operation |

## Verification
The assertions check the following on every cycle: the ZERO flag agrees with each non-port result, logic operations clear CARRY, the port value passes through with both flags frozen, plain register addition produces the correct 9-bit sum, the outputs stay put while idle, and `resultValid` follows the strobe. Only the bench's scenarios show that subtraction produces the borrow, that the carry-including forms take in the stored flag, that each fill choice works in both shift directions, and that the immediate path is selected correctly. These cases rely on a chain of flag values built up across successive operations.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'd0,
    GRP_ARITH = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_PORT  = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CY   = 2'd2,
    CIN_NCY  = 2'd3
  } cin_e;

  typedef enum logic [1:0] {
    CYS_HOLD  = 2'd0,
    CYS_CLEAR = 2'd1,
    CYS_ADDER = 2'd2,
    CYS_SHIFT = 2'd3
  } cysrc_e;

  typedef struct packed {
    logic       loadRes;
    logic       loadZero;
    cysrc_e     cySrc;
    grp_e       grp;
    logic [1:0] logicOp;
    logic       invB;
    logic       borrow;
    cin_e       cinMode;
    logic       shiftRight;
    logic [1:0] injSel;
    logic       injConst;
  } alu_ctl_t;

endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] opGroup,
  input  logic [1:0] subOp,
  input  logic       shiftRight,
  input  logic [1:0] injSel,
  input  logic       injConst,
  output alu_ctl_t   ctl
);

  grp_e grp;
  assign grp = grp_e'(opGroup);

  always_comb begin
    ctl            = '0;
    ctl.grp        = grp;
    ctl.logicOp    = subOp;
    ctl.shiftRight = shiftRight;
    ctl.injSel     = injSel;
    ctl.injConst   = injConst;
    ctl.invB       = subOp[1];
    ctl.borrow     = subOp[1];
    unique case (subOp)
      2'd0:    ctl.cinMode = CIN_ZERO;
      2'd1:    ctl.cinMode = CIN_CY;
      2'd2:    ctl.cinMode = CIN_ONE;
      default: ctl.cinMode = CIN_NCY;
    endcase
    ctl.loadRes  = valid;
    ctl.loadZero = valid && (grp != GRP_PORT);
    if (!valid) begin
      ctl.cySrc = CYS_HOLD;
    end else begin
      unique case (grp)
        GRP_LOGIC: ctl.cySrc = CYS_CLEAR;
        GRP_ARITH: ctl.cySrc = CYS_ADDER;
        GRP_SHIFT: ctl.cySrc = CYS_SHIFT;
        default:   ctl.cySrc = CYS_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  alu_ctl_t      ctl,
  input  logic          useImm,
  input  logic [DW-1:0] regA,
  input  logic [DW-1:0] regB,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] portIn,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          zero,
  output logic          resultValid
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] opB;
  logic [DW-1:0] logicRes;
  logic [DW-1:0] addB;
  logic [DW:0]   sum;
  logic          cin;
  logic          arithCy;
  logic          fillBit;
  logic          shiftOut;
  logic [DW-1:0] shiftRes;
  logic [DW-1:0] resNext;
  logic          cyNext;

  assign opB = useImm ? imm : regB;

  // per-bit four-way logic selection
  for (genvar i = 0; i < DW; i++) begin : g_logic
    always_comb begin
      unique case (ctl.logicOp)
        2'd0:    logicRes[i] = opB[i];
        2'd1:    logicRes[i] = regA[i] & opB[i];
        2'd2:    logicRes[i] = regA[i] | opB[i];
        default: logicRes[i] = regA[i] ^ opB[i];
      endcase
    end
  end

  // single shared adder; complement and carry-in select the form
  assign addB = ctl.invB ? ~opB : opB;

  always_comb begin
    unique case (ctl.cinMode)
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      CIN_CY:   cin = carry;
      default:  cin = ~carry;
    endcase
  end

  assign sum     = {1'b0, regA} + {1'b0, addB} + {{DW{1'b0}}, cin};
  assign arithCy = ctl.borrow ? ~sum[DW] : sum[DW];

  // shared shift/rotate selection with injected fill bit
  always_comb begin
    unique case (ctl.injSel)
      2'd0:    fillBit = ctl.injConst;
      2'd1:    fillBit = carry;
      2'd2:    fillBit = ctl.shiftRight ? regA[0] : regA[MSB];
      default: fillBit = ctl.shiftRight ? regA[MSB] : regA[0];
    endcase
  end

  assign shiftRes = ctl.shiftRight ? {fillBit, regA[MSB:1]} : {regA[MSB-1:0], fillBit};
  assign shiftOut = ctl.shiftRight ? regA[0] : regA[MSB];

  // final four-way merge
  always_comb begin
    unique case (ctl.grp)
      GRP_LOGIC: resNext = logicRes;
      GRP_ARITH: resNext = sum[DW-1:0];
      GRP_SHIFT: resNext = shiftRes;
      default:   resNext = portIn;
    endcase
  end

  always_comb begin
    unique case (ctl.cySrc)
      CYS_CLEAR: cyNext = 1'b0;
      CYS_ADDER: cyNext = arithCy;
      CYS_SHIFT: cyNext = shiftOut;
      default:   cyNext = carry;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      carry       <= 1'b0;
      zero        <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctl.loadRes;
      carry       <= cyNext;
      if (ctl.loadRes)  result <= resNext;
      if (ctl.loadZero) zero   <= ~|resNext;
    end
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid,
  input  logic [1:0]    opGroup,
  input  logic [1:0]    subOp,
  input  logic          shiftRight,
  input  logic [1:0]    injSel,
  input  logic          injConst,
  input  logic          useImm,
  input  logic [DW-1:0] regA,
  input  logic [DW-1:0] regB,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] portIn,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          zero,
  output logic          resultValid
);

  alu_ctl_t ctl;

  byte_alu_ctrl u_ctrl (
    .valid      (valid),
    .opGroup    (opGroup),
    .subOp      (subOp),
    .shiftRight (shiftRight),
    .injSel     (injSel),
    .injConst   (injConst),
    .ctl        (ctl)
  );

  byte_alu_dp #(.DW(DW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .useImm      (useImm),
    .regA        (regA),
    .regB        (regB),
    .imm         (imm),
    .portIn      (portIn),
    .result      (result),
    .carry       (carry),
    .zero        (zero),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          valid,
  input logic [1:0]    opGroup,
  input logic [1:0]    subOp,
  input logic          useImm,
  input logic [DW-1:0] regA,
  input logic [DW-1:0] regB,
  input logic [DW-1:0] portIn,
  input logic [DW-1:0] result,
  input logic          carry,
  input logic          zero,
  input logic          resultValid
);

  assert_zero_tracks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opGroup != 2'd3) |=> (zero == (result == '0)));

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opGroup == 2'd0) |=> !carry);

  assert_port_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opGroup == 2'd3) |=>
      (result == $past(portIn) && $stable(carry) && $stable(zero)));

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opGroup == 2'd1 && subOp == 2'd0 && !useImm) |=>
      ({carry, result} == ({1'b0, $past(regA)} + {1'b0, $past(regB)})));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(result) && $stable(carry) && $stable(zero)));

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (resultValid == $past(valid)));

endmodule

bind byte_alu byte_alu_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .valid       (valid),
  .opGroup     (opGroup),
  .subOp       (subOp),
  .useImm      (useImm),
  .regA        (regA),
  .regB        (regB),
  .portIn      (portIn),
  .result      (result),
  .carry       (carry),
  .zero        (zero),
  .resultValid (resultValid)
);

// File: tb/test_byte_alu.sv
module test_byte_alu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] opGroup = '0;
  logic [1:0] subOp = '0;
  logic       shiftRight = 1'b0;
  logic [1:0] injSel = '0;
  logic       injConst = 1'b0;
  logic       useImm = 1'b0;
  logic [7:0] regA = '0;
  logic [7:0] regB = '0;
  logic [7:0] imm = '0;
  logic [7:0] portIn = '0;
  logic [7:0] result;
  logic       carry;
  logic       zero;
  logic       resultValid;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  byte_alu i_byte_alu (
    .clk(clk), .rstN(rstN), .valid(valid), .opGroup(opGroup), .subOp(subOp),
    .shiftRight(shiftRight), .injSel(injSel), .injConst(injConst), .useImm(useImm),
    .regA(regA), .regB(regB), .imm(imm), .portIn(portIn),
    .result(result), .carry(carry), .zero(zero), .resultValid(resultValid)
  );

  // {grp,sub,dir,inj,cst,useImm, a,b,imm,port, expRes,expC,expZ}
  localparam int NV = 19;
  localparam logic [50:0] VEC [NV] = '{
    {2'd0,2'd0,1'b0,2'd0,1'b0,1'b1, 8'h3C,8'h11,8'hA5,8'h00, 8'hA5,1'b0,1'b0}, // R1 R2 pass imm
    {2'd0,2'd1,1'b0,2'd0,1'b0,1'b0, 8'hF0,8'h3C,8'h00,8'h00, 8'h30,1'b0,1'b0}, // R2 and
    {2'd0,2'd2,1'b0,2'd0,1'b0,1'b1, 8'hF0,8'h00,8'h0F,8'h00, 8'hFF,1'b0,1'b0}, // R2 or
    {2'd0,2'd3,1'b0,2'd0,1'b0,1'b0, 8'h5A,8'h5A,8'h00,8'h00, 8'h00,1'b0,1'b1}, // R2 R9 xor
    {2'd1,2'd0,1'b0,2'd0,1'b0,1'b0, 8'hC8,8'h64,8'h00,8'h00, 8'h2C,1'b1,1'b0}, // R3 add
    {2'd1,2'd1,1'b0,2'd0,1'b0,1'b0, 8'h01,8'hFE,8'h00,8'h00, 8'h00,1'b1,1'b1}, // R3 addcy
    {2'd1,2'd2,1'b0,2'd0,1'b0,1'b1, 8'h10,8'h00,8'h20,8'h00, 8'hF0,1'b1,1'b0}, // R4 sub borrow
    {2'd1,2'd3,1'b0,2'd0,1'b0,1'b0, 8'h20,8'h10,8'h00,8'h00, 8'h0F,1'b0,1'b0}, // R4 subcy cy=1
    {2'd1,2'd3,1'b0,2'd0,1'b0,1'b0, 8'h05,8'h05,8'h00,8'h00, 8'h00,1'b0,1'b1}, // R4 subcy cy=0
    {2'd2,2'd0,1'b0,2'd0,1'b1,1'b0, 8'h81,8'h00,8'h00,8'h00, 8'h03,1'b1,1'b0}, // R5 const 1
    {2'd2,2'd0,1'b0,2'd1,1'b0,1'b0, 8'h40,8'h00,8'h00,8'h00, 8'h81,1'b0,1'b0}, // R5 carry in
    {2'd2,2'd0,1'b0,2'd2,1'b0,1'b0, 8'h80,8'h00,8'h00,8'h00, 8'h01,1'b1,1'b0}, // R5 rotate
    {2'd2,2'd0,1'b0,2'd3,1'b0,1'b0, 8'h01,8'h00,8'h00,8'h00, 8'h03,1'b0,1'b0}, // R5 lsb dup
    {2'd2,2'd0,1'b1,2'd0,1'b0,1'b0, 8'h01,8'h00,8'h00,8'h00, 8'h00,1'b1,1'b1}, // R6 R9 const 0
    {2'd2,2'd0,1'b1,2'd1,1'b0,1'b0, 8'h02,8'h00,8'h00,8'h00, 8'h81,1'b0,1'b0}, // R6 carry in
    {2'd2,2'd0,1'b1,2'd2,1'b0,1'b0, 8'h03,8'h00,8'h00,8'h00, 8'h81,1'b1,1'b0}, // R6 rotate
    {2'd2,2'd0,1'b1,2'd3,1'b0,1'b0, 8'h85,8'h00,8'h00,8'h00, 8'hC2,1'b1,1'b0}, // R6 arith
    {2'd3,2'd0,1'b0,2'd0,1'b0,1'b0, 8'h77,8'h00,8'h00,8'h00, 8'h00,1'b1,1'b0}, // R7 port, flags held
    {2'd0,2'd0,1'b0,2'd0,1'b0,1'b1, 8'hFF,8'hFF,8'h00,8'h00, 8'h00,1'b0,1'b1}  // R8 clears carry
  };
  localparam string TAG [NV] = '{"R1","R2","R2","R9","R3","R3","R4","R4","R4",
    "R5","R5","R5","R5","R6","R6","R6","R6","R7","R8"};

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [50:0] v);
    opGroup = v[50:49]; subOp = v[48:47]; shiftRight = v[46]; injSel = v[45:44];
    injConst = v[43]; useImm = v[42]; regA = v[41:34]; regB = v[33:26];
    imm = v[25:18]; portIn = v[17:10];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset result", int'(result), 0);
    check("R11", "reset carry", int'(carry), 0);
    check("R11", "reset zero", int'(zero), 0);
    check("R11", "reset resultValid", int'(resultValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      valid = 1'b1;
      if (i == 17) portIn = 8'h00;
      @(negedge clk);
      check(TAG[i], $sformatf("vec %0d result", i), int'(result), int'(VEC[i][9:2]));
      check(TAG[i], $sformatf("vec %0d carry", i), int'(carry), int'(VEC[i][1]));
      check(TAG[i], $sformatf("vec %0d zero", i), int'(zero), int'(VEC[i][0]));
      check("R11", $sformatf("vec %0d resultValid", i), int'(resultValid), 1);
    end

    // R10: set carry=1, zero=0, result=0x2C, then idle with changing inputs
    drive(VEC[4]);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    opGroup = 2'd0; subOp = 2'd0; useImm = 1'b1; imm = 8'h00; regA = 8'h00;
    @(negedge clk);
    check("R11", "resultValid drops", int'(resultValid), 0);
    repeat (2) @(negedge clk);
    check("R10", "idle result", int'(result), 8'h2C);
    check("R10", "idle carry", int'(carry), 1);
    check("R10", "idle zero", int'(zero), 0);

    // R11: one-cycle latency, value appears after exactly one edge
    opGroup = 2'd3; portIn = 8'h5E; valid = 1'b1;
    @(posedge clk); #1;
    check("R11", "latency result", int'(result), 8'h5E);
    valid = 1'b0;
    @(negedge clk);

    // R11: reset mid-run clears all outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R11", "mid reset result", int'(result), 0);
    check("R11", "mid reset carry", int'(carry), 0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule